// File: doc/BRIEF.md
# External Asynchronous Memory Bus Controller

This block sits between an on-chip request port and external asynchronous memory. An on-chip client presents a byte address, write data, two byte-lane enables and a read/write flag under a valid/ready handshake. The block then runs one external bus cycle and reports completion with a one-cycle response pulse. Read data comes back with the response. Each access has an address phase, marked by an address latch enable pulse. A strobe phase follows, and a low ready input can stretch it. While an access is active, one of four active-low chip selects is driven, chosen from the top address bits.

Three static configuration inputs set the external bus. The first picks the data width: 16 bits as two byte lanes, or 8 bits on lane 0 only. The second picks separate or multiplexed address/data. The third picks the write-strobe scheme. In split mode, each lane has its own low-active write strobe. In combined mode, a single write strobe is used together with a low-active byte-high enable. An 8-bit bus always uses the combined scheme. An external master can claim the bus through an active-low hold input. The block finishes any access in progress, acknowledges the hold and turns off every output enable until the hold is released. The ready and hold inputs pass through two-flop synchronizers.

Top module: `ebi_ctrl`

## Requirements
- R1: After reset, `req_ready`=1, `bus_hlda_n`=1, `bus_ale`=0, `bus_cs_n`=4'hF, `bus_rd_n`=`bus_wr_lo_n`=`bus_wr_hi_n`=1, `rsp_valid`=0 and `bus_dout_oe`=2'b00.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The address phase follows for exactly one cycle with `bus_ale`=1. The strobe phase comes next. If ready is high, the strobe lasts exactly one cycle and `rsp_valid` is high for one cycle right after it.
- R3: During the address and strobe phases, only `bus_cs_n[addr[23:22]]` is low. When no access is active, all chip selects are high.
- R4: During an access, `bus_addr` carries the request address with bit 23 inverted and all other bits unchanged.
- R5: In multiplexed mode, the address phase drives addr[7:0] on lane 0 (`bus_dout[7:0]`). On a 16-bit bus it also drives addr[15:8] on lane 1, and `bus_dout_oe` is 2'b11. On an 8-bit bus, `bus_dout_oe` is 2'b01. In separate mode, `bus_dout_oe` is 2'b00 during the address phase.
- R6: In a write strobe phase, `bus_dout` carries the write data. `bus_dout_oe` is 2'b11 on a 16-bit bus and 2'b01 on an 8-bit bus.
- R7: In split mode on a 16-bit bus, a write drives `bus_wr_lo_n` low in the strobe cycle if `req_be[0]` (even byte, bits 7:0) is set. It drives `bus_wr_hi_n` low if `req_be[1]` (odd byte, bits 15:8) is set.
- R8: In combined mode, `bus_wr_lo_n` goes low in the strobe cycle of every write. `bus_wr_hi_n` acts as byte-high enable and is low in both phases when the odd byte is accessed. The odd byte is `req_be[1]` on a 16-bit bus and addr[0] on an 8-bit bus.
- R9: With `cfg_byte_bus`=1, the block behaves as in combined mode even when `cfg_single_wr`=0.
- R10: A read drives `bus_rd_n` low in the strobe phase and keeps both lanes undriven there. `rsp_rdata` is the sampled `bus_din`, zero-extended from lane 0 on an 8-bit bus.
- R11: While synchronized `bus_rdy_n` is low, the strobe phase holds with a stable address. The strobe ends on the third rising edge after `bus_rdy_n` returns high.
- R12: A low `bus_hold_n` drops `req_ready` from the second rising edge. When idle, it drives `bus_hlda_n` low from the third rising edge. An access in progress completes first. While the hold is acknowledged, `bus_ctl_oe`, `bus_addr_oe` and `bus_dout_oe` are all 0, and no request is accepted.
- R13: After `bus_hold_n` returns high, `bus_hlda_n` rises on the third rising edge. A pending request is then accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte_bus | input | 1 | 1 = 8-bit external bus, 0 = 16-bit |
| cfg_mux | input | 1 | 1 = multiplexed address/data |
| cfg_single_wr | input | 1 | 1 = combined write strobe plus byte-high enable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables (16-bit bus) |
| req_we | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Access completed |
| rsp_rdata | output | 16 | Read data |
| bus_addr | output | 24 | External address, bit 23 inverted |
| bus_addr_oe | output | 1 | Address output enable |
| bus_dout | output | 16 | Data/address lane outputs |
| bus_dout_oe | output | 2 | Per-lane output enables |
| bus_din | input | 16 | Data lane inputs |
| bus_ale | output | 1 | Address latch enable |
| bus_cs_n | output | 4 | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe |
| bus_wr_lo_n | output | 1 | Low-lane write strobe, or single write strobe |
| bus_wr_hi_n | output | 1 | High-lane write strobe, or byte-high enable |
| bus_ctl_oe | output | 1 | Control output enable |
| bus_rdy_n | input | 1 | Wait request, active low |
| bus_hold_n | input | 1 | Bus hold request, active low |
| bus_hlda_n | output | 1 | Hold acknowledge, active low |

## Verification
Each access result has a fixed cycle once the acceptance edge is known. The address phase is visible one edge after acceptance, the strobe two edges after, and the response three edges after. Ready and hold changes take effect on the third edge because of the two synchronizer flops. The bench changes inputs on falling edges and samples on falling edges. It counts edges explicitly from the stimulus to each sample, so every sample lands in the exact phase a requirement names. It does not wait on the outputs.

// File: rtl/ebi_pkg.sv
package ebi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_STRB = 2'd2,
        ST_HOLD = 2'd3
    } ebi_state_e;

    typedef struct packed {
        logic ale;
        logic rd_n;
        logic wr_lo_n;
        logic wr_hi_n;
    } ebi_ctl_t;

    localparam ebi_ctl_t CTL_QUIET = '{ale: 1'b0, rd_n: 1'b1, wr_lo_n: 1'b1, wr_hi_n: 1'b1};

    // an 8-bit bus cannot use per-lane strobes
    function automatic logic use_single(input logic byte_bus, input logic single_sel);
        return single_sel | byte_bus;
    endfunction

    function automatic logic odd_lane(input logic byte_bus, input logic addr0,
                                      input logic [1:0] be);
        return byte_bus ? addr0 : be[1];
    endfunction

endpackage

// File: rtl/ebi_sync.sv
module ebi_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ebi_strobe.sv
module ebi_strobe
    import ebi_pkg::*;
(
    input  ebi_state_e state,
    input  logic       we,
    input  logic [1:0] be,
    input  logic       addr0,
    input  logic       byte_bus,
    input  logic       single_sel,
    output ebi_ctl_t   ctl
);
    logic single;
    logic odd;

    always_comb begin
        single = use_single(byte_bus, single_sel);
        odd    = odd_lane(byte_bus, addr0, be);
        ctl    = CTL_QUIET;
        case (state)
            ST_ADDR: begin
                ctl.ale = 1'b1;
                if (single) ctl.wr_hi_n = ~odd;
            end
            ST_STRB: begin
                if (single) begin
                    ctl.wr_hi_n = ~odd;
                    if (we) ctl.wr_lo_n = 1'b0;
                end else if (we) begin
                    ctl.wr_lo_n = ~be[0];
                    ctl.wr_hi_n = ~be[1];
                end
                if (!we) ctl.rd_n = 1'b0;
            end
            default: ctl = CTL_QUIET;
        endcase
    end
endmodule

// File: rtl/ebi_csdec.sv
module ebi_csdec #(
    parameter int CS_N = 4,
    localparam int CS_W = $clog2(CS_N)
) (
    input  logic            active,
    input  logic [CS_W-1:0] sel,
    output logic [CS_N-1:0] cs_n
);
    for (genvar i = 0; i < CS_N; i++) begin : g_cs
        assign cs_n[i] = ~(active && (sel == CS_W'(i)));
    end
endmodule

// File: rtl/ebi_ctrl.sv
module ebi_ctrl
    import ebi_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int LANE_W      = 8,
    parameter int CS_N        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_byte_bus,
    input  logic                cfg_mux,
    input  logic                cfg_single_wr,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    input  logic [1:0]          req_be,
    input  logic                req_we,
    output logic                rsp_valid,
    output logic [2*LANE_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_addr_oe,
    output logic [2*LANE_W-1:0] bus_dout,
    output logic [1:0]          bus_dout_oe,
    input  logic [2*LANE_W-1:0] bus_din,
    output logic                bus_ale,
    output logic [CS_N-1:0]     bus_cs_n,
    output logic                bus_rd_n,
    output logic                bus_wr_lo_n,
    output logic                bus_wr_hi_n,
    output logic                bus_ctl_oe,
    input  logic                bus_rdy_n,
    input  logic                bus_hold_n,
    output logic                bus_hlda_n
);
    localparam int DATA_W = 2 * LANE_W;
    localparam int CS_W   = $clog2(CS_N);

    ebi_state_e          state;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [1:0]          be_q;
    logic                we_q;
    logic                rdy_s;
    logic                hold_s;
    ebi_ctl_t            ctl;
    logic [1:0]          lanes_on;

    ebi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
        .clk(clk), .rst(rst), .d(bus_rdy_n), .q(rdy_s));

    ebi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hold_sync (
        .clk(clk), .rst(rst), .d(bus_hold_n), .q(hold_s));

    assign req_ready = (state == ST_IDLE) && hold_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            wdata_q   <= '0;
            be_q      <= '0;
            we_q      <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (!hold_s) begin
                        state <= ST_HOLD;
                    end else if (req_valid) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        be_q    <= req_be;
                        we_q    <= req_we;
                        state   <= ST_ADDR;
                    end
                end
                ST_ADDR: state <= ST_STRB;
                ST_STRB: begin
                    if (rdy_s) begin
                        rsp_valid <= 1'b1;
                        if (!we_q)
                            rsp_rdata <= cfg_byte_bus ?
                                {{LANE_W{1'b0}}, bus_din[LANE_W-1:0]} : bus_din;
                        state <= ST_IDLE;
                    end
                end
                default: if (hold_s) state <= ST_IDLE;
            endcase
        end
    end

    ebi_strobe u_strobe (
        .state(state), .we(we_q), .be(be_q), .addr0(addr_q[0]),
        .byte_bus(cfg_byte_bus), .single_sel(cfg_single_wr), .ctl(ctl));

    ebi_csdec #(.CS_N(CS_N)) u_csdec (
        .active((state == ST_ADDR) || (state == ST_STRB)),
        .sel(addr_q[ADDR_W-1 -: CS_W]),
        .cs_n(bus_cs_n));

    assign lanes_on = {~cfg_byte_bus, 1'b1};

    always_comb begin
        bus_dout    = '0;
        bus_dout_oe = 2'b00;
        if (state == ST_ADDR && cfg_mux) begin
            bus_dout    = addr_q[DATA_W-1:0];
            bus_dout_oe = lanes_on;
        end else if (state == ST_STRB && we_q) begin
            bus_dout    = wdata_q;
            bus_dout_oe = lanes_on;
        end
    end

    assign bus_addr    = {~addr_q[ADDR_W-1], addr_q[ADDR_W-2:0]};
    assign bus_addr_oe = (state != ST_HOLD);
    assign bus_ctl_oe  = (state != ST_HOLD);
    assign bus_hlda_n  = (state != ST_HOLD);
    assign bus_ale     = ctl.ale;
    assign bus_rd_n    = ctl.rd_n;
    assign bus_wr_lo_n = ctl.wr_lo_n;
    assign bus_wr_hi_n = ctl.wr_hi_n;

    // R2: address phase lasts one cycle and leads into the strobe phase
    p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !bus_ale);
    p_ale_to_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> (state == ST_STRB));
    p_rsp_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(state == ST_STRB));
    // R3: at most one chip select, none when idle
    p_cs_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));
    p_cs_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (&bus_cs_n));
    // R9: on an 8-bit bus the high strobe only appears as an odd-byte enable
    p_byte_bhe_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_byte_bus && !bus_wr_hi_n) |-> bus_addr[0]);
    // R10: read and write strobes never overlap
    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_lo_n));
    // R11: waiting keeps the strobe phase and the address
    p_wait_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STRB && !rdy_s) |=> (state == ST_STRB && $stable(bus_addr)));
    // R12: acknowledge only from idle, and everything floats while held
    p_hold_from_idle_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_hlda_n) |-> $past(state == ST_IDLE));
    p_hold_float_r12: assert property (@(posedge clk) disable iff (rst)
        !bus_hlda_n |-> (!bus_ctl_oe && !bus_addr_oe && bus_dout_oe == 2'b00));
endmodule

// File: tb/tb_ebi_ctrl.sv
module tb_ebi_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_byte_bus, cfg_mux, cfg_single_wr;
    logic        req_valid, req_ready, req_we;
    logic [23:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_be;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [23:0] bus_addr;
    logic        bus_addr_oe;
    logic [15:0] bus_dout, bus_din;
    logic [1:0]  bus_dout_oe;
    logic        bus_ale, bus_rd_n, bus_wr_lo_n, bus_wr_hi_n, bus_ctl_oe;
    logic [3:0]  bus_cs_n;
    logic        bus_rdy_n, bus_hold_n, bus_hlda_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    ebi_ctrl dut (
        .clk(clk), .rst(rst), .cfg_byte_bus(cfg_byte_bus), .cfg_mux(cfg_mux),
        .cfg_single_wr(cfg_single_wr), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_we(req_we),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
        .bus_addr_oe(bus_addr_oe), .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe),
        .bus_din(bus_din), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_lo_n(bus_wr_lo_n), .bus_wr_hi_n(bus_wr_hi_n), .bus_ctl_oe(bus_ctl_oe),
        .bus_rdy_n(bus_rdy_n), .bus_hold_n(bus_hold_n), .bus_hlda_n(bus_hlda_n));

    // observations per phase
    logic        a_ale, a_whi;
    logic [3:0]  a_cs;
    logic [23:0] a_addr;
    logic [15:0] a_dout;
    logic [1:0]  a_oe;
    logic        s_ale, s_rd, s_wlo, s_whi;
    logic [3:0]  s_cs;
    logic [15:0] s_dout;
    logic [1:0]  s_oe;
    logic        e_rsp, e_rd, e_wlo;
    logic [3:0]  e_cs;
    logic [15:0] e_rdata;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_access(input logic [23:0] a, input logic [15:0] wd,
                             input logic [1:0] be, input logic we, input logic [15:0] din);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_wdata = wd; req_be = be; req_we = we;
        bus_din = din;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        a_ale = bus_ale; a_whi = bus_wr_hi_n; a_cs = bus_cs_n; a_addr = bus_addr;
        a_dout = bus_dout; a_oe = bus_dout_oe;
        @(negedge clk);
        s_ale = bus_ale; s_rd = bus_rd_n; s_wlo = bus_wr_lo_n; s_whi = bus_wr_hi_n;
        s_cs = bus_cs_n; s_dout = bus_dout; s_oe = bus_dout_oe;
        @(negedge clk);
        e_rsp = rsp_valid; e_rd = bus_rd_n; e_wlo = bus_wr_lo_n; e_cs = bus_cs_n;
        e_rdata = rsp_rdata;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready", req_ready, 1); chk("R1", "hlda_n", bus_hlda_n, 1);
        chk("R1", "ale", bus_ale, 0); chk("R1", "cs_n", bus_cs_n, 4'hF);
        chk("R1", "strobes", {bus_rd_n, bus_wr_lo_n, bus_wr_hi_n}, 3'b111);
        chk("R1", "rsp_valid", rsp_valid, 0); chk("R1", "dout_oe", bus_dout_oe, 0);
    endtask

    task automatic t_sep16_split;
        cfg_byte_bus = 0; cfg_mux = 0; cfg_single_wr = 0;
        do_access(24'h812345, 16'hBEEF, 2'b01, 1'b1, 16'h0);
        chk("R2", "ale addr phase", a_ale, 1); chk("R2", "ale strobe phase", s_ale, 0);
        chk("R2", "rsp pulse", e_rsp, 1);
        chk("R3", "cs addr phase", a_cs, 4'b1011); chk("R3", "cs strobe", s_cs, 4'b1011);
        chk("R3", "cs after", e_cs, 4'hF);
        chk("R4", "addr bit23 inverted", a_addr, 24'h012345);
        chk("R5", "separate addr phase oe", a_oe, 2'b00);
        chk("R6", "write data", s_dout, 16'hBEEF); chk("R6", "write oe", s_oe, 2'b11);
        chk("R7", "even wr_lo", s_wlo, 0); chk("R7", "even wr_hi", s_whi, 1);
        chk("R2", "strobe one cycle", e_wlo, 1);
        chk("R7", "no bhe in split", a_whi, 1);
        do_access(24'h000102, 16'h1122, 2'b10, 1'b1, 16'h0);
        chk("R7", "odd wr_lo", s_wlo, 1); chk("R7", "odd wr_hi", s_whi, 0);
        chk("R4", "addr bit23 low", a_addr, 24'h800102);
        chk("R3", "cs space0", a_cs, 4'b1110);
    endtask

    task automatic t_mux16_read;
        cfg_byte_bus = 0; cfg_mux = 1; cfg_single_wr = 1;
        do_access(24'h4055AA, 16'h0, 2'b11, 1'b0, 16'h1234);
        chk("R5", "mux addr lanes", a_dout, 16'h55AA); chk("R5", "mux oe", a_oe, 2'b11);
        chk("R3", "cs space1", a_cs, 4'b1101);
        chk("R8", "bhe addr phase", a_whi, 0); chk("R8", "bhe strobe", s_whi, 0);
        chk("R10", "rd low", s_rd, 0); chk("R10", "no write strobe", s_wlo, 1);
        chk("R10", "read lanes off", s_oe, 2'b00);
        chk("R10", "rd released", e_rd, 1); chk("R10", "rdata", e_rdata, 16'h1234);
        do_access(24'hC00010, 16'h0, 2'b01, 1'b0, 16'h5A5A);
        chk("R8", "even read no bhe", s_whi, 1); chk("R3", "cs space3", s_cs, 4'b0111);
    endtask

    task automatic t_single16_write;
        cfg_byte_bus = 0; cfg_mux = 0; cfg_single_wr = 1;
        do_access(24'h000200, 16'hA1B2, 2'b01, 1'b1, 16'h0);
        chk("R8", "wr low", s_wlo, 0); chk("R8", "no bhe", s_whi, 1);
        do_access(24'h000200, 16'hA1B2, 2'b11, 1'b1, 16'h0);
        chk("R8", "wr low word", s_wlo, 0); chk("R8", "bhe word", s_whi, 0);
        chk("R8", "bhe addr phase", a_whi, 0);
    endtask

    task automatic t_byte_bus;
        cfg_byte_bus = 1; cfg_mux = 1; cfg_single_wr = 0;
        do_access(24'h000013, 16'h00C3, 2'b00, 1'b1, 16'h0);
        chk("R5", "mux8 lane0", a_dout[7:0], 8'h13); chk("R5", "mux8 oe", a_oe, 2'b01);
        chk("R9", "forced single wr", s_wlo, 0); chk("R9", "odd bhe", s_whi, 0);
        chk("R9", "odd bhe addr", a_whi, 0);
        chk("R6", "byte data", s_dout[7:0], 8'hC3); chk("R6", "byte oe", s_oe, 2'b01);
        do_access(24'h000012, 16'h003C, 2'b11, 1'b1, 16'h0);
        chk("R9", "even no bhe", s_whi, 1); chk("R9", "even wr", s_wlo, 0);
        do_access(24'h000012, 16'h0, 2'b11, 1'b0, 16'hABCD);
        chk("R10", "byte read zero ext", e_rdata, 16'h00CD);
    endtask

    task automatic t_wait;
        cfg_byte_bus = 0; cfg_mux = 0; cfg_single_wr = 1;
        @(negedge clk);
        bus_rdy_n = 1'b0; req_valid = 1'b1; req_addr = 24'h123456; req_we = 1'b0;
        req_be = 2'b11; bus_din = 16'h7E7E;
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11", "stretched rd", bus_rd_n, 0);
            chk("R11", "addr stable", bus_addr, 24'h923456);
        end
        bus_rdy_n = 1'b1;
        @(negedge clk); chk("R11", "rd after 1 edge", bus_rd_n, 0);
        @(negedge clk); chk("R11", "rd after 2 edges", bus_rd_n, 0);
        @(negedge clk); chk("R11", "rd after 3 edges", bus_rd_n, 1);
        chk("R11", "rsp after wait", rsp_valid, 1);
        chk("R11", "rdata after wait", rsp_rdata, 16'h7E7E);
    endtask

    task automatic t_hold_idle;
        @(negedge clk); bus_hold_n = 1'b0;
        @(negedge clk); chk("R12", "ready edge1", req_ready, 1);
        @(negedge clk); chk("R12", "ready edge2", req_ready, 0);
        chk("R12", "hlda edge2", bus_hlda_n, 1);
        req_valid = 1'b1; req_addr = 24'h000040; req_we = 1'b1; req_wdata = 16'h0F0F;
        req_be = 2'b11;
        @(negedge clk); chk("R12", "hlda edge3", bus_hlda_n, 0);
        chk("R12", "float", {bus_ctl_oe, bus_addr_oe, bus_dout_oe}, 4'b0000);
        repeat (3) @(negedge clk);
        chk("R12", "no accept in hold", {bus_ale, bus_hlda_n, req_ready}, 3'b000);
        bus_hold_n = 1'b1;
        @(negedge clk); chk("R13", "hlda rel edge1", bus_hlda_n, 0);
        @(negedge clk); chk("R13", "hlda rel edge2", bus_hlda_n, 0);
        @(negedge clk); chk("R13", "hlda rel edge3", bus_hlda_n, 1);
        chk("R13", "ready after hold", req_ready, 1);
        @(negedge clk); chk("R13", "pending accepted", bus_ale, 1);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_hold_busy;
        @(negedge clk);
        bus_rdy_n = 1'b0; req_valid = 1'b1; req_addr = 24'h000080; req_we = 1'b0;
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk); bus_hold_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R12", "access continues", {bus_hlda_n, bus_rd_n}, 2'b10);
        end
        bus_rdy_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12", "access done first", {bus_rd_n, rsp_valid, bus_hlda_n}, 3'b111);
        @(negedge clk); chk("R12", "hold after access", bus_hlda_n, 0);
        bus_hold_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R13", "released", bus_hlda_n, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 0; req_addr = '0; req_wdata = '0; req_be = '0;
        req_we = 0; bus_din = '0; bus_rdy_n = 1; bus_hold_n = 1;
        cfg_byte_bus = 0; cfg_mux = 0; cfg_single_wr = 0;
        t_reset;
        t_sep16_split;
        t_mux16_read;
        t_single16_write;
        t_byte_bus;
        t_wait;
        t_hold_idle;
        t_hold_busy;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule